// File: doc/BRIEF.md
# Prioritized Relocatable Memory-Map Decoder

This block turns every 16-bit CPU address into one chip-select among five targets: the debug ROM window, the internal register block, the on-chip RAM, the EEPROM, and external memory. The register block, the RAM and the EEPROM each sit at a base address that software can move, so two or more of them can overlap. A fixed ranking then settles which target wins. An address that no internal target claims goes to external memory.

While the debug input is high, the top page of the map (0xFF00 to 0xFFFF) belongs to the debug logic, and no user target is selected there. A sideband flag marks the small slice of that page that holds the debug control registers. Base addresses are changed through a plain write port. A change reaches the decode only after a fixed pipeline delay. In normal operating modes each base accepts just one write after reset. In special (test) modes a base can be rewritten any number of times. A read port returns the base value that is currently in force.

Top module: `memmap_decoder`

## Requirements
- R1: After reset, reads return the reset bases: register block 0x0000, RAM 0x0800 and EEPROM 0xF000. The region sizes are 512 bytes, 1 KB and 4 KB, and `sel_o` starts as 5'b00001.
- R2: `sel_o` is registered. It reflects the address presented one cycle earlier, and exactly one of its bits is set. The bit meanings are: bit0 external, bit1 EEPROM, bit2 RAM, bit3 register block, bit4 debug ROM.
- R3: When regions overlap, the winner is chosen in this order: register block, then RAM, then EEPROM. An address claimed by none of them selects external memory.
- R4: While `dbg_active_i` is high, any address with upper byte 0xFF selects the debug ROM (bit4). `dbg_ctl_o` is high only for 0xFF00 to 0xFF06, with the same one-cycle latency.
- R5: While `dbg_active_i` is low, the 0xFFxx page is decoded like any other address, and `dbg_ctl_o` stays low.
- R6: Suppose a base write is presented in cycle k. An address presented in cycle k or k+1 is still decoded with the old base. An address presented in cycle k+2 is decoded with the new base.
- R7: With `special_mode_i` low, only the first accepted write to each base after reset takes effect. Later writes to that base change neither reads nor decode.
- R8: With `special_mode_i` high, every write to a base takes effect, even when the base was written before.
- R9: Write data bits below the region size are dropped, so each base is aligned to its region size. The `wr_sel_i` codes are: 0 register block, 1 RAM, 2 EEPROM. Code 3 is ignored.
- R10: `rd_data_o` shows the committed base for `rd_sel_i` as it stood one cycle earlier, using the same codes as `wr_sel_i`. Code 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode_i | input | 1 | High: bases may be rewritten freely |
| dbg_active_i | input | 1 | Debug mode is active |
| addr_i | input | 16 | CPU address to decode |
| wr_en_i | input | 1 | Base write strobe |
| wr_sel_i | input | 2 | Base to write (0 regs, 1 RAM, 2 EEPROM) |
| wr_data_i | input | 16 | New base address |
| rd_sel_i | input | 2 | Base to read back |
| rd_data_o | output | 16 | Committed base value |
| sel_o | output | 5 | One-hot target select |
| dbg_ctl_o | output | 1 | Address hits the debug control registers |

## Verification
A wrong base, lock flag or pending entry always shows up at the ports. A wrong base changes `sel_o` for every address in the affected window, and the readback shows it one cycle after it is requested. A lost or duplicated pending write shifts the change in `sel_o` away from the third cycle after the write. The bench checks that exact cycle for a relocated address. A lock flag that clears too early, or sets too late, lets a second write in normal mode move a region. The next decode or readback inside the old and new windows then exposes it. Random relocations that overlap the regions check both the ranking and the one-hot property over the whole address space.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int NUM_RGN = 3;
  localparam int NUM_SEL = 5;

  typedef enum logic [1:0] {
    RGN_REGS = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_EE   = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  localparam int SEL_EXT  = 0;
  localparam int SEL_EE   = 1;
  localparam int SEL_RAM  = 2;
  localparam int SEL_REGS = 3;
  localparam int SEL_DBG  = 4;
endpackage

// File: rtl/memmap_base_bank.sv
module memmap_base_bank #(
  parameter int ADDR_W  = 16,
  parameter int REG_LG2 = 9,
  parameter int RAM_LG2 = 10,
  parameter int EE_LG2  = 12,
  parameter logic [ADDR_W-1:0] REG_DEF = 16'h0000,
  parameter logic [ADDR_W-1:0] RAM_DEF = 16'h0800,
  parameter logic [ADDR_W-1:0] EE_DEF  = 16'hF000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   special_i,
  input  logic                   wr_en_i,
  input  logic [1:0]             wr_sel_i,
  input  logic [ADDR_W-1:0]      wr_data_i,
  output logic [2:0][ADDR_W-1:0] base_o
);
  import memmap_pkg::*;

  logic [NUM_RGN-1:0] acc;
  logic [NUM_RGN-1:0] lock_q;
  logic               pend_vld;
  logic [1:0]         pend_idx;
  logic [ADDR_W-1:0]  pend_data;

  // Single-entry staging: accepted write sits here one cycle before commit
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_idx  <= 2'd0;
      pend_data <= '0;
    end else begin
      pend_vld  <= |acc;
      pend_idx  <= wr_sel_i;
      pend_data <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    localparam int LG = (g == 0) ? REG_LG2 : (g == 1) ? RAM_LG2 : EE_LG2;
    localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} << LG;
    localparam logic [ADDR_W-1:0] DEF  = (g == 0) ? REG_DEF : (g == 1) ? RAM_DEF : EE_DEF;

    assign acc[g] = wr_en_i && (wr_sel_i == 2'(g)) && (special_i || !lock_q[g]);

    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[g] <= DEF & MASK;
        lock_q[g] <= 1'b0;
      end else begin
        if (acc[g]) lock_q[g] <= 1'b1;
        if (pend_vld && pend_idx == 2'(g)) base_o[g] <= pend_data & MASK;
      end
    end

    // R7: a locked base in normal mode must not enqueue a write
    assert_locked_ignored_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_en_i && wr_sel_i == 2'(g) && lock_q[g] && !special_i)
        |=> !(pend_vld && pend_idx == 2'(g)));
    // R6: a base only moves when a staged write for it commits
    assert_commit_via_stage_R6: assert property (@(posedge clk) disable iff (rst)
      !(pend_vld && pend_idx == 2'(g)) |=> $stable(base_o[g]));
    // R8: special mode always stages a write to a real base
    assert_special_accepts_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_en_i && wr_sel_i == 2'(g) && special_i)
        |=> (pend_vld && pend_idx == 2'(g)));
  end
endmodule

// File: rtl/memmap_region_match.sv
module memmap_region_match #(
  parameter int ADDR_W = 16,
  parameter int LG2    = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              hit_o
);
  localparam int TAG_W = ADDR_W - LG2;

  assign hit_o = (addr_i[ADDR_W-1:LG2] == base_i[ADDR_W-1:LG2]) && (TAG_W > 0);
endmodule

// File: rtl/memmap_resolve.sv
module memmap_resolve (
  input  logic       dbg_win_i,
  input  logic [2:0] hit_i,
  output logic [4:0] sel_o
);
  import memmap_pkg::*;

  always_comb begin
    sel_o = '0;
    if (dbg_win_i)           sel_o[SEL_DBG]  = 1'b1;
    else if (hit_i[RGN_REGS]) sel_o[SEL_REGS] = 1'b1;
    else if (hit_i[RGN_RAM])  sel_o[SEL_RAM]  = 1'b1;
    else if (hit_i[RGN_EE])   sel_o[SEL_EE]   = 1'b1;
    else                      sel_o[SEL_EXT]  = 1'b1;
  end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder #(
  parameter int ADDR_W   = 16,
  parameter int REG_LG2  = 9,
  parameter int RAM_LG2  = 10,
  parameter int EE_LG2   = 12,
  parameter int DBG_LG2  = 8,
  parameter int CTL_LAST = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              special_mode_i,
  input  logic              dbg_active_i,
  input  logic [15:0]       addr_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [15:0]       wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [15:0]       rd_data_o,
  output logic [4:0]        sel_o,
  output logic              dbg_ctl_o
);
  import memmap_pkg::*;

  localparam int DBG_TAG_W = ADDR_W - DBG_LG2;

  logic [2:0][ADDR_W-1:0] base;
  logic [2:0]             hit;
  logic                   dbg_win;
  logic                   dbg_ctl;
  logic [4:0]             sel_d;

  memmap_base_bank #(
    .ADDR_W (ADDR_W),
    .REG_LG2(REG_LG2),
    .RAM_LG2(RAM_LG2),
    .EE_LG2 (EE_LG2)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .special_i(special_mode_i),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .base_o   (base)
  );

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_match
    localparam int LG = (g == 0) ? REG_LG2 : (g == 1) ? RAM_LG2 : EE_LG2;
    memmap_region_match #(.ADDR_W(ADDR_W), .LG2(LG)) u_match (
      .addr_i(addr_i),
      .base_i(base[g]),
      .hit_o (hit[g])
    );
  end

  assign dbg_win = dbg_active_i && (addr_i[ADDR_W-1:DBG_LG2] == {DBG_TAG_W{1'b1}});
  assign dbg_ctl = dbg_win && (addr_i[DBG_LG2-1:0] <= DBG_LG2'(CTL_LAST));

  memmap_resolve u_resolve (
    .dbg_win_i(dbg_win),
    .hit_i    (hit),
    .sel_o    (sel_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o     <= 5'b00001;
      dbg_ctl_o <= 1'b0;
      rd_data_o <= '0;
    end else begin
      sel_o     <= sel_d;
      dbg_ctl_o <= dbg_ctl;
      rd_data_o <= (rd_sel_i == RGN_NONE) ? '0 : base[rd_sel_i];
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_o) == 1);
  assert_regs_first_R3: assert property (@(posedge clk) disable iff (rst)
    (hit[RGN_REGS] && !dbg_win) |=> sel_o[SEL_REGS]);
  assert_ram_over_ee_R3: assert property (@(posedge clk) disable iff (rst)
    (hit[RGN_RAM] && hit[RGN_EE] && !hit[RGN_REGS] && !dbg_win) |=> sel_o[SEL_RAM]);
  assert_dbg_wins_R4: assert property (@(posedge clk) disable iff (rst)
    dbg_win |=> sel_o[SEL_DBG]);
  assert_no_dbg_ctl_R5: assert property (@(posedge clk) disable iff (rst)
    !dbg_active_i |=> !dbg_ctl_o && !sel_o[SEL_DBG]);
endmodule

// File: tb/memmap_decoder_bench.sv
module memmap_decoder_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        special_mode_i = 1'b0;
  logic        dbg_active_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_sel_i = '0;
  logic [15:0] rd_data_o;
  logic [4:0]  sel_o;
  logic        dbg_ctl_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] eb [3];
  bit          lk [3];
  logic [15:0] mk [3];

  always #(PERIOD/2) clk = ~clk;

  memmap_decoder u_memmap_decoder (
    .clk(clk), .rst(rst), .special_mode_i(special_mode_i),
    .dbg_active_i(dbg_active_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .sel_o(sel_o), .dbg_ctl_o(dbg_ctl_o)
  );

  function automatic logic [4:0] exp_sel(logic [15:0] a, logic dbg);
    if (dbg && a[15:8] == 8'hFF) return 5'b10000;
    if ((a & mk[0]) == eb[0]) return 5'b01000;
    if ((a & mk[1]) == eb[1]) return 5'b00100;
    if ((a & mk[2]) == eb[2]) return 5'b00010;
    return 5'b00001;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_dec(string req, logic [15:0] a, logic dbg);
    logic ctl;
    addr_i = a; dbg_active_i = dbg;
    @(negedge clk);
    ctl = dbg && a[15:8] == 8'hFF && a[7:0] <= 8'd6;
    check(req, {11'd0, sel_o}, {11'd0, exp_sel(a, dbg)});
    check(req, {15'd0, dbg_ctl_o}, {15'd0, ctl});
  endtask

  task automatic chk_rd(string req, int idx);
    rd_sel_i = 2'(idx);
    @(negedge clk);
    check(req, rd_data_o, (idx == 3) ? 16'h0 : eb[idx]);
  endtask

  task automatic do_wr(int idx, logic [15:0] d);
    wr_en_i = 1'b1; wr_sel_i = 2'(idx); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    @(negedge clk);
    if (idx < 3 && (special_mode_i || !lk[idx])) begin
      eb[idx] = d & mk[idx];
      lk[idx] = 1;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    mk[0] = 16'hFE00; mk[1] = 16'hFC00; mk[2] = 16'hF000;
    eb[0] = 16'h0000; eb[1] = 16'h0800; eb[2] = 16'hF000;
    for (int i = 0; i < 3; i++) lk[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {11'd0, sel_o}, 16'h0001);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) chk_rd("R1/R10", i);
    // R2/R3 directed boundaries on defaults
    chk_dec("R3", 16'h0000, 0);
    chk_dec("R3", 16'h01FF, 0);
    chk_dec("R3", 16'h0200, 0);
    chk_dec("R3", 16'h0800, 0);
    chk_dec("R3", 16'h0BFF, 0);
    chk_dec("R3", 16'h0C00, 0);
    chk_dec("R3", 16'hF000, 0);
    chk_dec("R5", 16'hFFFF, 0);
    chk_dec("R5", 16'hFF03, 0);
    // R4 debug window
    chk_dec("R4", 16'hFF00, 1);
    chk_dec("R4", 16'hFF06, 1);
    chk_dec("R4", 16'hFF07, 1);
    chk_dec("R4", 16'hFFFF, 1);
    chk_dec("R4", 16'hFEFF, 1);
    // R6 latency: move RAM to 0x4000, watch address 0x4000
    addr_i = 16'h4000; dbg_active_i = 0;
    wr_en_i = 1; wr_sel_i = 2'd1; wr_data_i = 16'h4000;
    @(negedge clk);
    wr_en_i = 0;
    check("R6 cycle k", {11'd0, sel_o}, 16'h0001);
    @(negedge clk);
    check("R6 cycle k+1", {11'd0, sel_o}, 16'h0001);
    @(negedge clk);
    check("R6 cycle k+2", {11'd0, sel_o}, 16'h0004);
    eb[1] = 16'h4000; lk[1] = 1;
    // R7 write-once in normal mode
    do_wr(1, 16'h2000);
    chk_rd("R7", 1);
    chk_dec("R7", 16'h2000, 0);
    chk_dec("R7", 16'h4000, 0);
    do_wr(0, 16'h3000);
    do_wr(0, 16'h5000);
    chk_rd("R7", 0);
    chk_dec("R7", 16'h3000, 0);
    chk_dec("R7", 16'h5000, 0);
    // R9 code 3 ignored, low bits dropped
    do_wr(3, 16'h1234);
    for (int i = 0; i < 4; i++) chk_rd("R9", i);
    special_mode_i = 1;
    do_wr(2, 16'h1FFF);
    chk_rd("R9", 2);
    // R8 special rewrites, overlaps on purpose
    do_wr(1, 16'h1C00);
    chk_rd("R8", 1);
    do_wr(0, 16'h1E00);
    chk_rd("R8", 0);
    chk_dec("R3 overlap", 16'h1E10, 0);
    chk_dec("R3 overlap", 16'h1C10, 0);
    chk_dec("R3 overlap", 16'h1010, 0);
    // random relocations and decodes
    for (int r = 0; r < 60; r++) begin
      do_wr(int'($urandom_range(0, 3)), 16'($urandom));
      chk_rd("R8/R10", int'($urandom_range(0, 3)));
      for (int n = 0; n < 40; n++) begin
        logic [15:0] a;
        a = ($urandom_range(0, 3) == 0) ? eb[$urandom_range(0, 2)] + 16'($urandom_range(0, 1023))
                                        : 16'($urandom);
        chk_dec("R2/R3/R4", a, $urandom_range(0, 3) == 0);
      end
    end
    // back to normal mode: everything now locked
    special_mode_i = 0;
    do_wr(2, 16'h8000);
    chk_rd("R7", 2);
    chk_dec("R7", 16'h8000, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule